// File: doc/BRIEF.md
# Split-Access 64-bit Cycle and Retire Counters

This block keeps two 64-bit event counters behind a 32-bit control-register port: one counts clock cycles, the other counts retired instructions signalled by a one-cycle pulse. Each counter is reached as two 32-bit halves at machine-level addresses that can be read and written, and the same storage is also visible through read-only user-level addresses. A free-running 64-bit time value from outside the block is passed through to two user-level read addresses.

A processor core drives the register port from its control-register instruction path. It reads the counters as two halves, and it may preset either half at any time. The read data is combinational from the address and the current counter state. A write lands at the next clock edge. A write to the retire counter overrides the retire pulse of that same cycle. Because of this, the instruction that performs the write is not counted on top of the value it stored.

Top module: `perf_counter_bank`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both counters read as zero.
- R2: With no write to it, the cycle counter grows by one on every clock edge. The carry moves from bit 31 into bit 32, so the high half rises when the low half wraps from 0xFFFFFFFF to 0.
- R3: With no write to it, the retire counter grows by one on each edge where `retire_i` is high, and holds otherwise. The carry into the high half behaves as in R2.
- R4: Address map for reading and writing: 0xB00 is the cycle counter bits 31:0, 0xB80 is its bits 63:32, 0xB02 is the retire counter bits 31:0, and 0xB82 is its bits 63:32. `csr_rdata` shows the currently stored value of the addressed half.
- R5: A write with `csr_we` high stores `csr_wdata` unchanged into the addressed half at the next edge. The other half of that counter keeps its value, and there is no increment and no carry in that cycle.
- R6: A write to either half of the retire counter cancels that cycle's retire pulse, so the next value is exactly the written half joined with the untouched half.
- R7: User-level read addresses: 0xC00 and 0xC80 return the cycle counter halves, 0xC02 and 0xC82 return the retire counter halves, and 0xC01 and 0xC81 return `time_i` bits 31:0 and 63:32.
- R8: Writes to the user-level addresses, or to any address outside R4, change no counter state. A read of any address outside R4 and R7 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_we | input | 1 | Write strobe for the addressed half |
| csr_addr | input | 12 | Register address for reads and writes |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for `csr_addr`, combinational |
| retire_i | input | 1 | One pulse per retired instruction |
| time_i | input | 64 | External time value passed to the user read addresses |

## Verification
A wrong counter state shows up as a wrong read at the very next access to that half. For this reason the reference model is compared with the read port on every clock, and the address sweeps across all map entries, so a corrupted half is seen within a few cycles. Carry faults only show when the low half wraps, so both counters are preset just below the wrap point. Write-priority faults show as an off-by-one in the cycle after the write, so the written half is read back right away, both with and without a retire pulse in that cycle.

// File: rtl/perf_ctr_pkg.sv
package perf_ctr_pkg;
  localparam int unsigned ADDR_W = 12;

  localparam logic [ADDR_W-1:0] ADR_CYC_LO   = 12'hB00;
  localparam logic [ADDR_W-1:0] ADR_CYC_HI   = 12'hB80;
  localparam logic [ADDR_W-1:0] ADR_RET_LO   = 12'hB02;
  localparam logic [ADDR_W-1:0] ADR_RET_HI   = 12'hB82;
  localparam logic [ADDR_W-1:0] ADR_U_CYC_LO = 12'hC00;
  localparam logic [ADDR_W-1:0] ADR_U_CYC_HI = 12'hC80;
  localparam logic [ADDR_W-1:0] ADR_U_TIM_LO = 12'hC01;
  localparam logic [ADDR_W-1:0] ADR_U_TIM_HI = 12'hC81;
  localparam logic [ADDR_W-1:0] ADR_U_RET_LO = 12'hC02;
  localparam logic [ADDR_W-1:0] ADR_U_RET_HI = 12'hC82;

  typedef enum logic [2:0] {
    SRC_ZERO,
    SRC_CYC_LO,
    SRC_CYC_HI,
    SRC_RET_LO,
    SRC_RET_HI,
    SRC_TIM_LO,
    SRC_TIM_HI
  } rd_src_e;
endpackage

// File: rtl/perf_csr_decode.sv
module perf_csr_decode
  import perf_ctr_pkg::*;
(
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_cyc_lo,
  output logic              wr_cyc_hi,
  output logic              wr_ret_lo,
  output logic              wr_ret_hi,
  output rd_src_e           rd_src
);
  // Only the machine-level addresses accept writes; aliases are read-only.
  assign wr_cyc_lo = we && (addr == ADR_CYC_LO);
  assign wr_cyc_hi = we && (addr == ADR_CYC_HI);
  assign wr_ret_lo = we && (addr == ADR_RET_LO);
  assign wr_ret_hi = we && (addr == ADR_RET_HI);

  always_comb begin
    unique case (addr)
      ADR_CYC_LO, ADR_U_CYC_LO: rd_src = SRC_CYC_LO;
      ADR_CYC_HI, ADR_U_CYC_HI: rd_src = SRC_CYC_HI;
      ADR_RET_LO, ADR_U_RET_LO: rd_src = SRC_RET_LO;
      ADR_RET_HI, ADR_U_RET_HI: rd_src = SRC_RET_HI;
      ADR_U_TIM_LO:             rd_src = SRC_TIM_LO;
      ADR_U_TIM_HI:             rd_src = SRC_TIM_HI;
      default:                  rd_src = SRC_ZERO;
    endcase
  end
endmodule

// File: rtl/perf_split_counter.sv
module perf_split_counter #(
  parameter int unsigned HALF_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [HALF_W-1:0]   wdata,
  input  logic                inc,
  output logic [2*HALF_W-1:0] count
);
  localparam int unsigned CNT_W = 2 * HALF_W;

  // Next value: a half write wins over the increment; the increment carries fully.
  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0]  cur,
    input logic              lo_we,
    input logic              hi_we,
    input logic [HALF_W-1:0] d,
    input logic              step
  );
    logic [CNT_W-1:0] nv;
    nv = cur;
    if (lo_we || hi_we) begin
      if (lo_we) nv[HALF_W-1:0]     = d;
      if (hi_we) nv[CNT_W-1:HALF_W] = d;
    end else if (step) begin
      nv = cur + CNT_W'(1);
    end
    return nv;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= next_count(count, wr_lo, wr_hi, wdata, inc);
  end
endmodule

// File: rtl/perf_read_mux.sv
module perf_read_mux
  import perf_ctr_pkg::*;
#(
  parameter int unsigned HALF_W = 32
) (
  input  rd_src_e             src,
  input  logic [2*HALF_W-1:0] cyc,
  input  logic [2*HALF_W-1:0] ret,
  input  logic [2*HALF_W-1:0] tim,
  output logic [HALF_W-1:0]   rdata
);
  localparam int unsigned CNT_W = 2 * HALF_W;

  always_comb begin
    unique case (src)
      SRC_CYC_LO: rdata = cyc[HALF_W-1:0];
      SRC_CYC_HI: rdata = cyc[CNT_W-1:HALF_W];
      SRC_RET_LO: rdata = ret[HALF_W-1:0];
      SRC_RET_HI: rdata = ret[CNT_W-1:HALF_W];
      SRC_TIM_LO: rdata = tim[HALF_W-1:0];
      SRC_TIM_HI: rdata = tim[CNT_W-1:HALF_W];
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import perf_ctr_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic [XLEN-1:0]   csr_rdata,
  input  logic              retire_i,
  input  logic [2*XLEN-1:0] time_i
);
  localparam int unsigned CNT_W = 2 * XLEN;

  logic             wr_cyc_lo, wr_cyc_hi, wr_ret_lo, wr_ret_hi;
  rd_src_e          rd_src;
  logic             cyc_wr;       // software touched the cycle counter this cycle
  logic             ret_written;  // software touched the retire counter this cycle
  logic             cyc_inc;
  logic             ret_inc;
  logic [CNT_W-1:0] cyc_q;
  logic [CNT_W-1:0] ret_q;

  perf_csr_decode u_dec (
    .we        (csr_we),
    .addr      (csr_addr),
    .wr_cyc_lo (wr_cyc_lo),
    .wr_cyc_hi (wr_cyc_hi),
    .wr_ret_lo (wr_ret_lo),
    .wr_ret_hi (wr_ret_hi),
    .rd_src    (rd_src)
  );

  assign cyc_wr      = wr_cyc_lo | wr_cyc_hi;
  assign ret_written = wr_ret_lo | wr_ret_hi;
  assign cyc_inc     = ~cyc_wr;
  assign ret_inc     = retire_i & ~ret_written;

  perf_split_counter #(.HALF_W(XLEN)) u_cyc (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_lo (wr_cyc_lo),
    .wr_hi (wr_cyc_hi),
    .wdata (csr_wdata),
    .inc   (cyc_inc),
    .count (cyc_q)
  );

  perf_split_counter #(.HALF_W(XLEN)) u_ret (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_lo (wr_ret_lo),
    .wr_hi (wr_ret_hi),
    .wdata (csr_wdata),
    .inc   (ret_inc),
    .count (ret_q)
  );

  perf_read_mux #(.HALF_W(XLEN)) u_rd (
    .src   (rd_src),
    .cyc   (cyc_q),
    .ret   (ret_q),
    .tim   (time_i),
    .rdata (csr_rdata)
  );
endmodule

// File: rtl/perf_counter_bank_chk.sv
module perf_counter_bank_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csr_we,
  input logic [11:0]       csr_addr,
  input logic [XLEN-1:0]   csr_wdata,
  input logic              retire_i,
  input logic [2*XLEN-1:0] cyc_q,
  input logic [2*XLEN-1:0] ret_q,
  input logic              cyc_wr,
  input logic              ret_written
);
  localparam int unsigned CNT_W = 2 * XLEN;

  AST_CYC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_wr |=> cyc_q == $past(cyc_q) + CNT_W'(1)); // R2

  AST_RET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_i && !ret_written) |=> ret_q == $past(ret_q) + CNT_W'(1)); // R3

  AST_RET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire_i && !ret_written) |=> $stable(ret_q)); // R3

  AST_CYC_HI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == 12'hB80) |=>
      (cyc_q[CNT_W-1:XLEN] == $past(csr_wdata)) && (cyc_q[XLEN-1:0] == $past(cyc_q[XLEN-1:0]))); // R5

  AST_RET_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == 12'hB02) |=>
      (ret_q[XLEN-1:0] == $past(csr_wdata)) && (ret_q[CNT_W-1:XLEN] == $past(ret_q[CNT_W-1:XLEN]))); // R6

  AST_ALIAS_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr[11:8] == 4'hC) |-> (!cyc_wr && !ret_written)); // R8
endmodule

bind perf_counter_bank perf_counter_bank_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .csr_we      (csr_we),
  .csr_addr    (csr_addr),
  .csr_wdata   (csr_wdata),
  .retire_i    (retire_i),
  .cyc_q       (cyc_q),
  .ret_q       (ret_q),
  .cyc_wr      (cyc_wr),
  .ret_written (ret_written)
);

// File: tb/test_perf_counter_bank.sv
`timescale 1ns/1ps
module test_perf_counter_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [11:0] csr_addr = 12'h000;
  logic [31:0] csr_wdata = 32'h0;
  logic [31:0] csr_rdata;
  logic        retire_i = 1'b0;
  logic [63:0] time_i = 64'h0;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  perf_counter_bank i_perf_counter_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_we    (csr_we),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .retire_i  (retire_i),
    .time_i    (time_i)
  );

  // Behavioural reference: two 64-bit integers, updated on each edge.
  longint unsigned m_cyc, m_ret;
  longint unsigned n_cyc, n_ret;
  bit              touched;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cyc = 0;
      m_ret = 0;
    end else begin
      n_cyc = m_cyc + 1;
      n_ret = m_ret;
      touched = 1'b0;
      if (csr_we) begin
        if (csr_addr == 12'hB00) n_cyc = {m_cyc[63:32], csr_wdata};
        if (csr_addr == 12'hB80) n_cyc = {csr_wdata, m_cyc[31:0]};
        if (csr_addr == 12'hB02) begin n_ret = {m_ret[63:32], csr_wdata}; touched = 1'b1; end
        if (csr_addr == 12'hB82) begin n_ret = {csr_wdata, m_ret[31:0]}; touched = 1'b1; end
      end
      if (retire_i && !touched) n_ret = m_ret + 1;
      m_cyc = n_cyc;
      m_ret = n_ret;
    end
  end

  function automatic logic [31:0] ref_read(input logic [11:0] a);
    case (a)
      12'hB00, 12'hC00: return m_cyc[31:0];
      12'hB80, 12'hC80: return m_cyc[63:32];
      12'hB02, 12'hC02: return m_ret[31:0];
      12'hB82, 12'hC82: return m_ret[63:32];
      12'hC01:          return time_i[31:0];
      12'hC81:          return time_i[63:32];
      default:          return 32'h0;
    endcase
  endfunction

  task automatic step(input logic we, input logic [11:0] a, input logic [31:0] d,
                      input logic rt, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    csr_we = we; csr_addr = a; csr_wdata = d; retire_i = rt;
    #1;
    exp = ref_read(a);
    compared++;
    if (csr_rdata !== exp) begin
      mismatched++;
      $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, csr_rdata, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [15:0] lfsr;
    time_i = 64'h0123_4567_89AB_CDEF;
    // R1: reads during reset, including attempted writes
    step(0, 12'hB00, 0, 1, "R1");
    step(1, 12'hB82, 32'hFFFF_FFFF, 1, "R1");
    step(0, 12'hC02, 0, 1, "R1");
    @(negedge clk); rst_n = 1'b1;
    step(0, 12'hB80, 0, 0, "R1");
    // R2 and R3: free run with a retire pattern
    for (int i = 0; i < 6; i++) step(0, 12'hB00, 0, i[0], "R2");
    for (int i = 0; i < 6; i++) step(0, 12'hB02, 0, i[1], "R3");
    // R5: preset the cycle counter just below the wrap point
    step(1, 12'hB00, 32'hFFFF_FFFD, 0, "R5");
    step(1, 12'hB80, 32'h0000_0005, 0, "R5");
    step(0, 12'hB00, 0, 0, "R5");
    step(0, 12'hB80, 0, 0, "R2");
    step(0, 12'hB00, 0, 0, "R2");
    step(0, 12'hB80, 0, 0, "R2");
    step(0, 12'hB80, 0, 0, "R2");
    // R6: write to the retire counter with a retire pulse in the same cycle
    step(1, 12'hB02, 32'hFFFF_FFFF, 1, "R6");
    step(0, 12'hB02, 0, 1, "R6");
    step(0, 12'hB82, 0, 0, "R3");
    step(1, 12'hB82, 32'hDEAD_0001, 1, "R6");
    step(0, 12'hB82, 0, 0, "R6");
    step(0, 12'hB02, 0, 0, "R6");
    step(1, 12'hB02, 32'h0000_0010, 0, "R5");
    step(0, 12'hB02, 0, 0, "R5");
    // R8: alias and unmapped writes leave the state untouched
    step(1, 12'hC00, 32'h5555_5555, 0, "R8");
    step(1, 12'hC82, 32'hAAAA_AAAA, 1, "R8");
    step(1, 12'h123, 32'h1234_5678, 0, "R8");
    step(0, 12'h123, 0, 0, "R8");
    step(0, 12'hC82, 0, 0, "R8");
    step(0, 12'hC00, 0, 0, "R8");
    // R7: user reads of counters and time
    time_i = 64'hFEDC_BA98_7654_3210;
    step(0, 12'hC01, 0, 0, "R7");
    step(0, 12'hC81, 0, 1, "R7");
    step(0, 12'hC02, 0, 0, "R7");
    step(0, 12'hC80, 0, 0, "R7");
    // R4: mixed traffic over the whole map
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[3:0])
        4'd0: a = 12'hB00;  4'd1: a = 12'hB80;  4'd2: a = 12'hB02;
        4'd3: a = 12'hB82;  4'd4: a = 12'hC00;  4'd5: a = 12'hC80;
        4'd6: a = 12'hC01;  4'd7: a = 12'hC81;  4'd8: a = 12'hC02;
        4'd9: a = 12'hC82;  default: a = {4'h0, lfsr[11:4]};
      endcase
      time_i = time_i + 64'd3;
      step(lfsr[15:13] == 3'b000, a, {lfsr, lfsr ^ 16'h5A5A}, lfsr[4], "R4");
    end
    summary();
  end
endmodule